// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block runs one Serial Wire Debug register access from the host side. It drives the serial clock and a tri-stated data line. A single-cycle `start` pulse latches the four request fields, the write word and the options: turnaround length, data-phase-on-error and idle clock count. The block then sends the request packet and releases the line for the turnaround. It samples the three-bit acknowledge and then takes one of several paths. An accepted read captures the word and checks its parity. An accepted write sends the word with its parity. A WAIT or FAULT answer can pad the data phase with dummy clocks. Any other answer is treated as a protocol error and is followed by a fixed recovery stretch of clocks.

Each serial bit takes one SWCLK period. SWCLK is low for `half_period+1` system clocks and then high for the same time. The host changes its drive only at the falling SWCLK edge. It samples `swdio_i` on the system clock edge at which SWCLK rises. Between transfers SWCLK rests high and the line is driven high. The result appears on `ack` and `rdata` together with a one-cycle `done` pulse.

Top module: `swd_xfer_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, `swclk`=1, `swdio_oe`=1 and `swdio_o`=1, with `ack`=0 and `rdata`=0 after reset. All inputs are latched on an accepted `start`. A `start` pulse while `busy` is high has no effect.
- R2: Every SWCLK low phase and every high phase inside a transfer lasts `half_period+1` clock cycles. `swdio_o` and `swdio_oe` change during a transfer only in the cycle in which SWCLK falls.
- R3: The first eight SWCLK periods drive, in this order: 1, `req_apndp`, `req_rnw`, `req_a2`, `req_a3`, the XOR of those four bits, 0, 1.
- R4: `trn_len+1` periods with `swdio_oe`=0 follow the request. Then three acknowledge bits are sampled, the first one being bit 0. The raw encodings are OK=3'b001, WAIT=3'b010 and FAULT=3'b100.
- R5: On OK with a read, 32 data bits (LSB first) and a parity bit are sampled with the line released, followed by `trn_len+1` released periods. `rdata` takes the 32 bits. `ack` becomes 4'b0001 when the parity bit equals the XOR of the data bits, and 4'b1000 otherwise.
- R6: On OK with a write, `trn_len+1` released periods come first. Then 32 periods drive `wdata` LSB first, and one more period drives the XOR of `wdata`. `ack` becomes 4'b0001.
- R7: After any OK transfer, `idle_cnt` further periods drive the line low.
- R8: On WAIT or FAULT with `data_phase`=1 and a read, the engine gives 33 released periods, then `trn_len+1` released periods, then 33 periods driven low. Otherwise only the `trn_len+1` released periods follow. `ack` becomes {1'b0, raw ack}.
- R9: Any other raw acknowledge gives `trn_len+34` released periods. `ack` becomes {1'b0, raw ack}.
- R10: The transfer ends on a rising SWCLK edge. On that same edge `done` pulses for one cycle, `busy` falls, the line is driven high and `ack` holds the result. No further SWCLK edge follows.
- R11: `rdata` changes only at the end of the data phase of an OK read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| req_apndp | input | 1 | Request field: access port / debug port select |
| req_rnw | input | 1 | Request field: 1 = read, 0 = write |
| req_a2 | input | 1 | Request field: address bit 2 |
| req_a3 | input | 1 | Request field: address bit 3 |
| wdata | input | 32 | Write word |
| trn_len | input | TRN_W | Turnaround length minus one |
| data_phase | input | 1 | Pad the data phase after WAIT/FAULT on reads |
| idle_cnt | input | IDLE_W | Low-driven clocks after an OK transfer |
| half_period | input | DIV_W | SWCLK half period minus one, in clock cycles |
| swdio_i | input | 1 | Data line as seen at the pad |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line drive value |
| swdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack | output | 4 | Result code |
| rdata | output | 32 | Last word read with an OK acknowledge |

## Verification
Drive values for a serial bit are due on the system clock edge that pulls SWCLK low. The bench compares them at the next falling system clock edge, once per bit, against a slot list it builds from the request. It presents the target's reply bit at the same point, so the reply is settled well before the rising SWCLK edge where the engine samples it. `ack`, `rdata`, `done` and the idle line levels are due on the edge of the final SWCLK rise. They are checked at the falling system clock edge that follows it. The phase lengths are counted in whole cycles at every SWCLK transition.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

   localparam int DATA_W = 32;
   localparam int RES_W  = 4;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   localparam logic [RES_W-1:0] RES_PAR_ERR = 4'b1000;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_REQ,
      ST_TRN_REQ,
      ST_ACK,
      ST_RDATA,
      ST_TRN_RD,
      ST_TRN_WR,
      ST_WDATA,
      ST_IDLE_CYC,
      ST_DUMMY_RD,
      ST_TRN_ERR,
      ST_DUMMY_WR,
      ST_PROT
   } seq_st_e;

   // {output enable, level} for the bit slot that belongs to a state
   function automatic logic [1:0] slot_drive(seq_st_e st, logic sh0);
      case (st)
         ST_REQ, ST_WDATA:          return {1'b1, sh0};
         ST_IDLE_CYC, ST_DUMMY_WR:  return 2'b10;
         ST_IDLE:                   return 2'b11;
         default:                   return 2'b01;
      endcase
   endfunction

endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             run,
   input  logic [DIV_W-1:0] half_period,
   output logic             swclk,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] hp_q;
   logic             clk_q;
   logic             at_end;

   assign at_end   = run && (cnt_q == hp_q);
   assign rise_stb = at_end && !clk_q;
   assign fall_stb = at_end && clk_q;
   assign swclk    = clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hp_q  <= '0;
         clk_q <= 1'b1;
      end else if (go) begin
         cnt_q <= '0;
         hp_q  <= half_period;
         clk_q <= 1'b0;
      end else if (at_end) begin
         cnt_q <= '0;
         clk_q <= ~clk_q;
      end else if (run) begin
         cnt_q <= cnt_q + DIV_W'(1);
      end else begin
         cnt_q <= '0;
         clk_q <= 1'b1;
      end
   end

endmodule

// File: rtl/swd_xfer_fsm.sv
module swd_xfer_fsm
   import swd_xfer_pkg::*;
#(
   parameter int TRN_W  = 2,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_apndp,
   input  logic              req_rnw,
   input  logic              req_a2,
   input  logic              req_a3,
   input  logic [DATA_W-1:0] wdata,
   input  logic [TRN_W-1:0]  trn_len,
   input  logic              data_phase,
   input  logic [IDLE_W-1:0] idle_cnt,
   input  logic              swdio_i,
   input  logic              rise_stb,
   output logic              go,
   output logic              busy,
   output logic              finish,
   output seq_st_e           st,
   output logic              sh0,
   output logic              done,
   output logic [RES_W-1:0]  ack,
   output logic [DATA_W-1:0] rdata
);

   localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;
   localparam int SH_W  = DATA_W + 1;

   seq_st_e           st_q, st_n;
   logic [CNT_W-1:0]  left_q, left_n;
   logic [SH_W-1:0]   sh_q, rd_new;
   logic [2:0]        ack_q, ack_new;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [TRN_W-1:0]  trn_q;
   logic [IDLE_W-1:0] idle_q;
   logic              rnw_q, dp_q, perr_q;
   logic [RES_W-1:0]  res_q;
   logic              done_q;
   logic [CNT_W-1:0]  trn_left;
   logic              pad_err;

   assign go       = start && (st_q == ST_IDLE);
   assign busy     = (st_q != ST_IDLE);
   assign finish   = rise_stb && (st_n == ST_IDLE);
   assign st       = st_q;
   assign sh0      = sh_q[0];
   assign done     = done_q;
   assign ack      = res_q;
   assign rdata    = rdata_q;
   assign ack_new  = {swdio_i, ack_q[2:1]};
   assign rd_new   = {swdio_i, sh_q[SH_W-1:1]};
   assign trn_left = CNT_W'(trn_q);
   assign pad_err  = dp_q && rnw_q;

   always_comb begin
      st_n   = st_q;
      left_n = left_q - CNT_W'(1);
      if (left_q == '0) begin
         case (st_q)
            ST_REQ: begin
               st_n = ST_TRN_REQ;   left_n = trn_left;
            end
            ST_TRN_REQ: begin
               st_n = ST_ACK;       left_n = CNT_W'(2);
            end
            ST_ACK: begin
               if (ack_new == ACK_OK) begin
                  st_n   = rnw_q ? ST_RDATA : ST_TRN_WR;
                  left_n = rnw_q ? CNT_W'(DATA_W) : trn_left;
               end else if (ack_new == ACK_WAIT || ack_new == ACK_FAULT) begin
                  st_n   = pad_err ? ST_DUMMY_RD : ST_TRN_ERR;
                  left_n = pad_err ? CNT_W'(DATA_W) : trn_left;
               end else begin
                  st_n   = ST_PROT;
                  left_n = trn_left + CNT_W'(DATA_W + 1);
               end
            end
            ST_RDATA: begin
               st_n = ST_TRN_RD;    left_n = trn_left;
            end
            ST_TRN_WR: begin
               st_n = ST_WDATA;     left_n = CNT_W'(DATA_W);
            end
            ST_TRN_RD, ST_WDATA: begin
               st_n   = (idle_q != '0) ? ST_IDLE_CYC : ST_IDLE;
               left_n = CNT_W'(idle_q) - CNT_W'(1);
            end
            ST_DUMMY_RD: begin
               st_n = ST_TRN_ERR;   left_n = trn_left;
            end
            ST_TRN_ERR: begin
               st_n   = pad_err ? ST_DUMMY_WR : ST_IDLE;
               left_n = CNT_W'(DATA_W);
            end
            default: begin
               st_n = ST_IDLE;      left_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         left_q  <= '0;
         sh_q    <= '0;
         ack_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         trn_q   <= '0;
         idle_q  <= '0;
         rnw_q   <= 1'b0;
         dp_q    <= 1'b0;
         perr_q  <= 1'b0;
         res_q   <= '0;
      end else if (go) begin
         st_q    <= ST_REQ;
         left_q  <= CNT_W'(7);
         sh_q    <= {{(SH_W-8){1'b0}}, 1'b1, 1'b0,
                     req_apndp ^ req_rnw ^ req_a2 ^ req_a3,
                     req_a3, req_a2, req_rnw, req_apndp, 1'b1};
         ack_q   <= '0;
         wdata_q <= wdata;
         trn_q   <= trn_len;
         idle_q  <= idle_cnt;
         rnw_q   <= req_rnw;
         dp_q    <= data_phase;
         perr_q  <= 1'b0;
      end else if (rise_stb) begin
         st_q   <= st_n;
         left_q <= left_n;
         case (st_q)
            ST_REQ, ST_WDATA: sh_q <= sh_q >> 1;
            ST_ACK: begin
               ack_q <= ack_new;
               if (left_q == '0 && ack_new == ACK_OK && !rnw_q)
                  sh_q <= {^wdata_q, wdata_q};
            end
            ST_RDATA: begin
               sh_q <= rd_new;
               if (left_q == '0) begin
                  rdata_q <= rd_new[DATA_W-1:0];
                  perr_q  <= rd_new[DATA_W] ^ (^rd_new[DATA_W-1:0]);
               end
            end
            default: ;
         endcase
         if (st_n == ST_IDLE) begin
            if (ack_q == ACK_OK && rnw_q && perr_q)
               res_q <= RES_PAR_ERR;
            else
               res_q <= {1'b0, ack_q};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= finish;
   end

endmodule

// File: rtl/swd_line_drv.sv
module swd_line_drv
   import swd_xfer_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go,
   input  logic    fall_stb,
   input  logic    finish,
   input  seq_st_e st,
   input  logic    sh0,
   output logic    swdio_o,
   output logic    swdio_oe
);

   logic [1:0] drv;
   logic       out_q, oe_q;

   assign drv      = slot_drive(st, sh0);
   assign swdio_o  = out_q;
   assign swdio_oe = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b1;
         oe_q  <= 1'b1;
      end else if (go || finish) begin
         // start bit, or the parked-high line after the last bit
         out_q <= 1'b1;
         oe_q  <= 1'b1;
      end else if (fall_stb) begin
         oe_q  <= drv[1];
         out_q <= drv[0];
      end
   end

endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
   import swd_xfer_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int TRN_W  = 2,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_apndp,
   input  logic              req_rnw,
   input  logic              req_a2,
   input  logic              req_a3,
   input  logic [31:0]       wdata,
   input  logic [TRN_W-1:0]  trn_len,
   input  logic              data_phase,
   input  logic [IDLE_W-1:0] idle_cnt,
   input  logic [DIV_W-1:0]  half_period,
   input  logic              swdio_i,
   output logic              swclk,
   output logic              swdio_o,
   output logic              swdio_oe,
   output logic              busy,
   output logic              done,
   output logic [3:0]        ack,
   output logic [31:0]       rdata
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
      if (TRN_W < 1 || TRN_W > 4) begin : g_bad_trn
         $error("TRN_W must lie in 1..4");
      end
      if (IDLE_W < 1 || IDLE_W > 16) begin : g_bad_idle
         $error("IDLE_W must lie in 1..16");
      end
   endgenerate

   logic    go, run, finish, rise_stb, fall_stb, sh0;
   seq_st_e st;

   assign run = busy;

   swd_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .run         (run),
      .half_period (half_period),
      .swclk       (swclk),
      .rise_stb    (rise_stb),
      .fall_stb    (fall_stb)
   );

   swd_xfer_fsm #(.TRN_W(TRN_W), .IDLE_W(IDLE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .req_apndp  (req_apndp),
      .req_rnw    (req_rnw),
      .req_a2     (req_a2),
      .req_a3     (req_a3),
      .wdata      (wdata),
      .trn_len    (trn_len),
      .data_phase (data_phase),
      .idle_cnt   (idle_cnt),
      .swdio_i    (swdio_i),
      .rise_stb   (rise_stb),
      .go         (go),
      .busy       (busy),
      .finish     (finish),
      .st         (st),
      .sh0        (sh0),
      .done       (done),
      .ack        (ack),
      .rdata      (rdata)
   );

   swd_line_drv u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .fall_stb (fall_stb),
      .finish   (finish),
      .st       (st),
      .sh0      (sh0),
      .swdio_o  (swdio_o),
      .swdio_oe (swdio_oe)
   );

endmodule

// File: rtl/swd_xfer_chk.sv
module swd_xfer_chk (
   input logic clk,
   input logic rst_n,
   input logic swclk,
   input logic swdio_o,
   input logic swdio_oe,
   input logic busy,
   input logic done
);

   // R1
   idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> swclk);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (swdio_oe && swdio_o));

   // R2
   oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $changed(swdio_oe)) |-> $fell(swclk));

   // R2
   level_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $changed(swdio_o)) |-> $fell(swclk));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(busy) && $rose(swclk)));

endmodule

bind swd_xfer_engine swd_xfer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .swclk    (swclk),
   .swdio_o  (swdio_o),
   .swdio_oe (swdio_oe),
   .busy     (busy),
   .done     (done)
);

// File: tb/swd_xfer_engine_tb.sv
module swd_xfer_engine_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_SLOTS  = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        apndp = 1'b0, rnw = 1'b0, a2 = 1'b0, a3 = 1'b0;
   logic [31:0] wdata = '0;
   logic [1:0]  trn_len = '0;
   logic        dphase = 1'b0;
   logic [7:0]  idle_cnt = '0;
   logic [7:0]  half_period = '0;
   logic        swdio_i = 1'b1;

   logic        swclk, swdio_o, swdio_oe, busy, done;
   logic [3:0]  ack;
   logic [31:0] rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   swd_xfer_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_apndp(apndp), .req_rnw(rnw), .req_a2(a2), .req_a3(a3),
      .wdata(wdata), .trn_len(trn_len), .data_phase(dphase),
      .idle_cnt(idle_cnt), .half_period(half_period), .swdio_i(swdio_i),
      .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
      .busy(busy), .done(done), .ack(ack), .rdata(rdata)
   );

   int n_chk = 0, n_fail = 0;

   // reference slot list: what the host drives and what the target answers
   bit          exp_oe [MAX_SLOTS];
   bit          exp_do [MAX_SLOTS];
   bit          tgt    [MAX_SLOTS];
   int          exp_tag[MAX_SLOTS];
   int          n_exp;
   logic [3:0]  exp_res = '0;
   logic [31:0] exp_rdata = '0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic push(input bit oe, input bit d, input bit t, input int tag);
      if (n_exp < MAX_SLOTS) begin
         exp_oe[n_exp] = oe; exp_do[n_exp] = d; tgt[n_exp] = t; exp_tag[n_exp] = tag;
         n_exp++;
      end
   endtask

   task automatic plan(input bit ap, input bit r, input bit b2, input bit b3,
                       input logic [31:0] wd, input int trn, input bit dp, input int idl,
                       input logic [2:0] ak, input logic [31:0] rd, input bit badp);
      n_exp = 0;
      // R3 request packet
      push(1, 1, 1, 3); push(1, ap, 1, 3); push(1, r, 1, 3); push(1, b2, 1, 3);
      push(1, b3, 1, 3); push(1, ap ^ r ^ b2 ^ b3, 1, 3); push(1, 0, 1, 3); push(1, 1, 1, 3);
      // R4 turnaround and acknowledge
      for (int k = 0; k <= trn; k++) push(0, 1, 1, 4);
      for (int k = 0; k < 3; k++) push(0, 1, ak[k], 4);
      if (ak == 3'b001) begin
         if (r) begin
            // R5
            for (int k = 0; k < 32; k++) push(0, 1, rd[k], 5);
            push(0, 1, (^rd) ^ badp, 5);
            for (int k = 0; k <= trn; k++) push(0, 1, 1, 5);
            exp_res = badp ? 4'b1000 : 4'b0001;
            exp_rdata = rd;
         end else begin
            // R6
            for (int k = 0; k <= trn; k++) push(0, 1, 1, 6);
            for (int k = 0; k < 32; k++) push(1, wd[k], 1, 6);
            push(1, ^wd, 1, 6);
            exp_res = 4'b0001;
         end
         // R7
         for (int k = 0; k < idl; k++) push(1, 0, 1, 7);
      end else if (ak == 3'b010 || ak == 3'b100) begin
         // R8
         if (dp && r) for (int k = 0; k < 33; k++) push(0, 1, 1, 8);
         for (int k = 0; k <= trn; k++) push(0, 1, 1, 8);
         if (dp && r) for (int k = 0; k < 33; k++) push(1, 0, 1, 8);
         exp_res = {1'b0, ak};
      end else begin
         // R9
         for (int k = 0; k < trn + 34; k++) push(0, 1, 1, 9);
         exp_res = {1'b0, ak};
      end
   endtask

   task automatic xfer(input string tag, input bit ap, input bit r, input bit b2, input bit b3,
                       input logic [31:0] wd, input int trn, input bit dp, input int idl,
                       input logic [2:0] ak, input logic [31:0] rd, input bit badp,
                       input int h, input bit inject);
      int  slot = -1;
      int  lowc = 0, highc = 0, cyc = 0;
      bit  prev = 1'b1;
      bit  inj_on = 1'b0;
      bit  stray = 1'b0;
      plan(ap, r, b2, b3, wd, trn, dp, idl, ak, rd, badp);
      @(negedge clk);
      apndp = ap; rnw = r; a2 = b2; a3 = b3; wdata = wd; trn_len = 2'(trn);
      dphase = dp; idle_cnt = 8'(idl); half_period = 8'(h); start = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (inj_on) begin
            inj_on = 1'b0;
            rnw = r; apndp = ap; wdata = wd;
         end
         if (prev && !swclk) begin
            slot++;
            if (slot > 0)
               chk(highc == h + 1, $sformatf("R2 high phase before slot %0d", slot), highc, h + 1);
            if (slot < n_exp) begin
               chk(swdio_oe === exp_oe[slot],
                   $sformatf("R%0d slot %0d enable", exp_tag[slot], slot), swdio_oe, exp_oe[slot]);
               if (exp_oe[slot])
                  chk(swdio_o === exp_do[slot],
                      $sformatf("R%0d slot %0d level", exp_tag[slot], slot), swdio_o, exp_do[slot]);
               swdio_i = tgt[slot];
            end else begin
               chk(1'b0, "R10 clock period beyond the expected end", slot, n_exp);
            end
            lowc = 1;
         end else if (!prev && swclk) begin
            chk(lowc == h + 1, $sformatf("R2 low phase of slot %0d", slot), lowc, h + 1);
            highc = 1;
         end else if (!swclk) begin
            lowc++;
         end else begin
            highc++;
         end
         prev = swclk;
         if (inject && slot == 10 && lowc == 1) begin
            // R1: a start pulse with other request fields while busy
            start = 1'b1; rnw = ~r; apndp = ~ap; wdata = ~wd; inj_on = 1'b1;
         end
         if (done) break;
         if (cyc > 20000) begin
            chk(1'b0, "R10 watchdog: transfer did not end", cyc, 0);
            break;
         end
      end
      swdio_i = 1'b1;
      chk(slot + 1 == n_exp, "R10 number of SWCLK periods", slot + 1, n_exp);
      chk(ack === exp_res, {tag, " result code"}, ack, exp_res);
      chk(rdata === exp_rdata, "R11 read data", rdata, exp_rdata);
      chk(swclk && swdio_oe && swdio_o && !busy, "R10 line parked high at end",
          {swclk, swdio_oe, swdio_o, busy}, 4'b1110);
      for (int k = 0; k < 4 * (h + 1) + 4; k++) begin
         @(negedge clk);
         if (!swclk || busy || !swdio_o || !swdio_oe) stray = 1'b1;
      end
      chk(!stray, "R10 no clock edge after the end", stray, 0);
      if (inject)
         chk(!stray && (slot + 1 == n_exp), "R1 start while busy ignored", slot + 1, n_exp);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(swclk === 1'b1 && swdio_oe === 1'b1 && swdio_o === 1'b1 && busy === 1'b0,
          "R1 reset line state", {swclk, swdio_oe, swdio_o, busy}, 4'b1110);
      chk(ack === 4'd0 && rdata === 32'd0, "R1 reset result", {ack, rdata}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 OK read, good parity
      xfer("R5", 0, 1, 0, 1, 32'h0, 0, 0, 0, 3'b001, 32'hA5C3_0F81, 0, 0, 0);
      // R6 R7 OK write, idle clocks, start ignored while busy (R1)
      xfer("R6", 1, 0, 1, 0, 32'h8000_1235, 1, 0, 3, 3'b001, 32'h0, 0, 2, 1);
      // R5 OK read, corrupted parity
      xfer("R5", 1, 1, 1, 1, 32'h0, 2, 0, 2, 3'b001, 32'h7FFF_0001, 1, 1, 0);
      // R8 WAIT on read with data phase: R11 keeps rdata
      xfer("R8", 0, 1, 1, 0, 32'h0, 1, 1, 0, 3'b010, 32'h0, 0, 1, 0);
      // R8 FAULT on write with data phase set: turnaround only
      xfer("R8", 1, 0, 0, 1, 32'h1234_5678, 0, 1, 5, 3'b100, 32'h0, 0, 0, 0);
      // R8 WAIT on read without data phase
      xfer("R8", 0, 1, 0, 0, 32'h0, 3, 0, 0, 3'b010, 32'h0, 0, 0, 0);
      // R9 protocol error, all ones
      xfer("R9", 1, 1, 0, 0, 32'h0, 3, 1, 4, 3'b111, 32'h0, 0, 1, 0);
      // R9 protocol error, no answer
      xfer("R9", 0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 3'b000, 32'h0, 0, 0, 0);
      // R6 OK write, longest turnaround, no idle clocks
      xfer("R6", 0, 0, 1, 1, 32'hFFFF_FFFE, 3, 0, 0, 3'b001, 32'h0, 0, 0, 0);
      // R5 R7 OK read after errors
      xfer("R5", 1, 1, 0, 1, 32'h0, 1, 1, 1, 3'b001, 32'h0000_0000, 0, 3, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule